// File: doc/BRIEF.md
# Serial CRC Residue Checker

This block checks a received frame one bit at a time. An init pulse presets a remainder register to all ones. After that, every cycle that carries a bit strobe shifts the data bit into the remainder through a parameterised generator polynomial. The new remainder is compared with a fixed residue, which is the bitwise inverse of a verification mask parameter. The result of that compare is registered and drives `crc_ok_o`. A frame that ends with the inverted check word of its own payload leaves the remainder equal to the residue.

Frame delimiting happens in a neighbouring block, which also supplies a byte-boundary strobe. On each byte strobe the block stores the current verdict in a one-bit latch, `byte_ok_o`. When the end-of-frame delimiter is recognised, the receiver reads this stored bit. It does not need to delay the bit stream by the width of the check word.

With the default parameters the polynomial is 0x1021 and the mask is 0xE2F0, so the residue is 0x1D0F. Data bits enter most significant bit first.

Top module: `crc_residue_checker`

## Requirements
- R1: While reset is low and on the first cycle after it, `crc_ok_o` and `byte_ok_o` are 0, and the remainder is all ones.
- R2: The cycle after `init_i` is high, `crc_ok_o` and `byte_ok_o` are 0, and the remainder is all ones again.
- R3: When `init_i` and `bit_vld_i` are high in the same cycle, the data bit is discarded. Bits that follow are accumulated from the all-ones preset.
- R4: On cycles where `bit_vld_i` is low, the remainder and `crc_ok_o` keep their values, whatever `bit_i` does.
- R5: On a bit strobe the remainder is updated as follows. Let f = `bit_i` XOR the remainder MSB. New bit 0 is f. Each new bit i ≥ 1 is old bit i-1, XORed with f when polynomial bit i is set.
- R6: The cycle after a bit strobe, `crc_ok_o` is 1 exactly when the updated remainder equals the bitwise inverse of the mask (0x1D0F by default). A payload followed by the inverse of its check word, sent MSB first, gives 1.
- R7: On a `byte_vld_i` cycle without init, `byte_ok_o` takes the verdict from the next cycle. If a bit strobe happens in the same cycle, that verdict already includes the bit.
- R8: Without `byte_vld_i` or `init_i`, `byte_ok_o` holds its value, even across bit strobes that change `crc_ok_o`.
- R9: When `init_i` and `byte_vld_i` are high together, init wins and `byte_ok_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start-of-frame pulse: presets the remainder and clears both verdicts |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | Strobe: accept `bit_i` this cycle |
| byte_vld_i | input | 1 | Strobe: byte boundary, latch the verdict |
| crc_ok_o | output | 1 | Registered verdict for the remainder |
| byte_ok_o | output | 1 | Verdict latched at the last byte boundary |

## Verification
The assertions assume the strobes are synchronous one-cycle-wide qualifiers. They also assume nothing other than `init_i` or `bit_vld_i` moves the verdict, and nothing other than `init_i` or `byte_vld_i` moves the latch.

The stimulus sends frames with random payloads. Each frame either ends with the correct inverted check word or has one bit flipped. The byte strobe comes either in the same cycle as the eighth bit strobe or in the cycle after it. Idle gaps toggle `bit_i` with no strobe. Directed cycles hit init together with a bit strobe, and init together with a byte strobe.

// File: rtl/crc_chk_pkg.sv
// Package: shared defaults for the serial CRC residue checker.
// Assumes: data bits arrive MSB first; the polynomial bit 0 is implied.
package crc_chk_pkg;
    localparam int          CRC_W_DEF = 16;
    localparam logic [15:0] POLY_DEF  = 16'h1021;
    localparam logic [15:0] MASK_DEF  = 16'hE2F0;

    // Verdict pair passed from the compare stage to the byte latch.
    typedef struct packed {
        logic nxt;  // verdict for the remainder after this cycle's bit
        logic cur;  // registered verdict
    } verdict_t;
endpackage

// File: rtl/crc_shift_reg.sv
// Module: remainder register with bit-serial polynomial feedback.
// Assumes: bit_vld_i marks one accepted bit per cycle; init has priority.
module crc_shift_reg #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         bit_i,
    input  logic         bit_vld_i,
    output logic [W-1:0] rem_next_o
);
    localparam logic [W-1:0] PRESET = '1;

    logic [W-1:0] rem_q;
    logic         fb;

    assign fb            = bit_i ^ rem_q[W-1];
    assign rem_next_o[0] = fb;

    // Feedback taps: one per polynomial bit above bit 0.
    for (genvar g = 1; g < W; g++) begin : g_tap
        if (POLY[g]) begin : g_xor
            assign rem_next_o[g] = rem_q[g-1] ^ fb;
        end else begin : g_pass
            assign rem_next_o[g] = rem_q[g-1];
        end
    end

    // Remainder update: preset on reset/init, shift on a bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         rem_q <= PRESET;
        else if (init_i)    rem_q <= PRESET;
        else if (bit_vld_i) rem_q <= rem_next_o;
    end
endmodule

// File: rtl/crc_residue_cmp.sv
// Module: registered compare of the next remainder against the residue.
// Assumes: the residue is the bitwise inverse of MASK (comparator only, no XOR stage).
module crc_residue_cmp #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = 16'hE2F0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic                  bit_vld_i,
    input  logic [W-1:0]          rem_next_i,
    output crc_chk_pkg::verdict_t verdict_o
);
    localparam logic [W-1:0] RESIDUE = ~MASK;

    logic ok_q;

    assign verdict_o.nxt = (rem_next_i == RESIDUE);
    assign verdict_o.cur = ok_q;

    // Verdict register: cleared by reset/init, refreshed on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         ok_q <= 1'b0;
        else if (init_i)    ok_q <= 1'b0;
        else if (bit_vld_i) ok_q <= verdict_o.nxt;
    end
endmodule

// File: rtl/crc_byte_latch.sv
// Module: one-bit snapshot of the verdict at byte boundaries.
// Assumes: byte_vld_i marks the cycle of, or after, the last bit of a byte.
module crc_byte_latch (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_i,
    input  logic                  bit_vld_i,
    input  logic                  byte_vld_i,
    input  crc_chk_pkg::verdict_t verdict_i,
    output logic                  byte_ok_o
);
    logic snap;

    assign snap = bit_vld_i ? verdict_i.nxt : verdict_i.cur;

    // Snapshot register: init clears, byte strobe captures.
    always_ff @(posedge clk) begin
        if (!rst_n)          byte_ok_o <= 1'b0;
        else if (init_i)     byte_ok_o <= 1'b0;
        else if (byte_vld_i) byte_ok_o <= snap;
    end
endmodule

// File: rtl/crc_residue_checker.sv
// Top: bit-serial CRC residue checker with per-byte verdict latch.
// Assumes: strobes are synchronous to clk; reset is synchronous active-low.
module crc_residue_checker #(
    parameter int                 W    = crc_chk_pkg::CRC_W_DEF,
    parameter logic [W-1:0]       POLY = crc_chk_pkg::POLY_DEF,
    parameter logic [W-1:0]       MASK = crc_chk_pkg::MASK_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic bit_i,
    input  logic bit_vld_i,
    input  logic byte_vld_i,
    output logic crc_ok_o,
    output logic byte_ok_o
);
    logic [W-1:0]          rem_next;
    crc_chk_pkg::verdict_t verdict;

    crc_shift_reg #(.W(W), .POLY(POLY)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .bit_i      (bit_i),
        .bit_vld_i  (bit_vld_i),
        .rem_next_o (rem_next)
    );

    crc_residue_cmp #(.W(W), .MASK(MASK)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .bit_vld_i  (bit_vld_i),
        .rem_next_i (rem_next),
        .verdict_o  (verdict)
    );

    crc_byte_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .bit_vld_i  (bit_vld_i),
        .byte_vld_i (byte_vld_i),
        .verdict_i  (verdict),
        .byte_ok_o  (byte_ok_o)
    );

    assign crc_ok_o = verdict.cur;
endmodule

// File: rtl/crc_residue_checker_chk.sv
// Checker: port-level temporal properties of the residue checker.
// Assumes: attached by bind to every instance of the top module.
module crc_residue_checker_chk (
    input logic clk,
    input logic rst_n,
    input logic init_i,
    input logic bit_vld_i,
    input logic byte_vld_i,
    input logic crc_ok_o,
    input logic byte_ok_o
);
    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!crc_ok_o && !byte_ok_o));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !bit_vld_i) |=> $stable(crc_ok_o));
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !byte_vld_i) |=> $stable(byte_ok_o));
    // R7
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !init_i && !bit_vld_i) |=> (byte_ok_o == $past(crc_ok_o)));
    // R7
    latch_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !init_i && bit_vld_i) |=> (byte_ok_o == crc_ok_o));
endmodule

bind crc_residue_checker crc_residue_checker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .bit_vld_i  (bit_vld_i),
    .byte_vld_i (byte_vld_i),
    .crc_ok_o   (crc_ok_o),
    .byte_ok_o  (byte_ok_o)
);

// File: tb/crc_residue_checker_tb.sv
module crc_residue_checker_tb;
    localparam logic [15:0] TB_POLY = 16'h1021;
    localparam logic [15:0] TB_RES  = 16'h1D0F;

    logic clk = 1'b0, rst_n = 1'b0;
    logic init_i = 1'b0, bit_i = 1'b0, bit_vld_i = 1'b0, byte_vld_i = 1'b0;
    logic crc_ok_o, byte_ok_o;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;
    string tag = "R1";

    logic [15:0] m_rem = 16'hFFFF;
    logic        m_ok = 1'b0, m_bok = 1'b0;

    always #10 clk = ~clk;

    crc_residue_checker u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .bit_i(bit_i),
        .bit_vld_i(bit_vld_i), .byte_vld_i(byte_vld_i),
        .crc_ok_o(crc_ok_o), .byte_ok_o(byte_ok_o)
    );

    // Reference step: MSB-first shift with feedback into tapped bits.
    function automatic logic [15:0] ref_step(logic [15:0] r, logic b);
        logic f = b ^ r[15];
        return {r[14:0], f} ^ ({16{f}} & TB_POLY & 16'hFFFE);
    endfunction

    task automatic check(logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(logic in_init, logic in_bit, logic in_vld, logic in_byte);
        init_i = in_init; bit_i = in_bit; bit_vld_i = in_vld; byte_vld_i = in_byte;
        @(posedge clk);
        if (!rst_n) begin
            m_rem = 16'hFFFF; m_ok = 1'b0; m_bok = 1'b0;
        end else if (in_init) begin
            m_rem = 16'hFFFF; m_ok = 1'b0; m_bok = 1'b0;
        end else begin
            if (in_byte) m_bok = in_vld ? (ref_step(m_rem, in_bit) == TB_RES) : m_ok;
            if (in_vld) begin
                m_rem = ref_step(m_rem, in_bit);
                m_ok  = (m_rem == TB_RES);
            end
        end
        @(negedge clk);
        check(crc_ok_o, m_ok, "crc_ok");
        check(byte_ok_o, m_bok, "byte_ok");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'($urandom), 1'b0, 1'b0);
    endtask

    // Sends payload plus inverted check word; optional flipped bit; byte strobe timing.
    task automatic send_frame(int nbytes, int flip_at, bit same_cycle);
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  buf_b [0:7];
        for (int i = 0; i < nbytes; i++) begin
            buf_b[i] = 8'($urandom);
            for (int k = 7; k >= 0; k--) c = ref_step(c, buf_b[i][k]);
        end
        buf_b[nbytes]   = ~c[15:8];
        buf_b[nbytes+1] = ~c[7:0];
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < nbytes + 2; i++) begin
            for (int k = 7; k >= 0; k--) begin
                logic b = buf_b[i][k] ^ ((i * 8 + (7 - k)) == flip_at);
                bit   last = (k == 0);
                cyc(1'b0, b, 1'b1, last && same_cycle);
                if ($urandom_range(0, 3) == 0) idle(1);
            end
            if (!same_cycle) cyc(1'b0, 1'($urandom), 1'b0, 1'b1);
        end
    endtask

    initial begin : watchdog
        while (!done && cycles < 150000) begin
            @(posedge clk); cycles++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0);

        tag = "R6";
        send_frame(2, -1, 1'b0);
        check(crc_ok_o, 1'b1, "R6 good frame verdict");
        check(byte_ok_o, 1'b1, "R7 good frame latch");

        tag = "R8";
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        check(byte_ok_o, 1'b1, "R8 latch holds across bit");
        check(crc_ok_o, 1'b0, "R8 verdict moved");

        tag = "R4";
        idle(6);

        tag = "R9";
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        check(byte_ok_o, 1'b0, "R9 init beats byte strobe");

        tag = "R2";
        send_frame(1, -1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check(crc_ok_o, 1'b0, "R2 init clears verdict");

        tag = "R3";
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        begin
            logic [15:0] c = 16'hFFFF;
            logic [7:0]  d = 8'hA5;
            for (int k = 7; k >= 0; k--) c = ref_step(c, d[k]);
            c = ~c;
            for (int k = 7; k >= 0; k--) cyc(1'b0, d[k], 1'b1, 1'b0);
            for (int k = 15; k >= 0; k--) cyc(1'b0, c[k], 1'b1, k == 0);
        end
        check(crc_ok_o, 1'b1, "R3 dropped bit under init");

        tag = "R5";
        for (int f = 0; f < 40; f++) begin
            int n = $urandom_range(1, 6);
            int flip = ($urandom_range(0, 2) == 0) ? $urandom_range(0, (n + 2) * 8 - 1) : -1;
            send_frame(n, flip, 1'($urandom));
            check(crc_ok_o, 1'(flip < 0), "R5 R6 frame verdict");
            tag = "R4";
            idle($urandom_range(0, 4));
            tag = "R5";
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule